// File: doc/BRIEF.md
# Serial Host Control Port

This block is the host-facing serial control port of a line transceiver. A host frames each access with an active-low select and clocks sixteen bits in, least significant bit first: a command byte, then a data byte. Bit 0 of the command byte chooses the direction. Command bit 5 is the device-select address bit and must be set for the port to respond. A write loads the configuration byte. That byte holds the transmit equalizer code, the remote and local loopback enables, the all-ones transmit request and two flag-clear bits. A write with both loopback bits set is a reset command.

On a read, the port shifts a byte back out during the data phase. The low five bits of that byte are the stored configuration. The top three bits carry a status code, and the code gives pending monitor events priority over configuration states. The port watches two monitor levels, loss-of-signal and driver-monitor. Any change of either level latches a flag and pulls an active-low interrupt. The serial output pad is modelled as data plus an output enable, and the interrupt pad is open-drain (it drives only when `irq_n` is low). All serial pins are oversampled by a fast system clock, so the serial clock must stay well below that clock.

Top module: `serial_host_port`

## Requirements
- R1: A frame with command bit 0 = 0 and command bit 5 = 1 commits the data byte after the 16th rising serial clock edge. The outputs then read as follows: `eq_code[0]`=D2, `eq_code[1]`=D3, `eq_code[2]`=D4, `rloop_en`=D5, `lloop_en`=D6, and the all-ones request is D7.
- R2: A frame with command bit 5 = 0 leaves the configuration unchanged and never enables `sdo`.
- R3: A frame ended by `cs_n` rising before the 16th rising serial clock edge leaves the configuration unchanged.
- R4: `sdo_oe` is low while `cs_n` is high, during write frames, and before the command byte is complete.
- R5: A read (command bit 0 = 1, bit 5 = 1) shifts out one byte, D0 first. Bits D0..D4 equal the stored configuration bits.
- R6: When no event flag is set, read bits (D5,D6,D7) are: 100 with remote loopback; otherwise D5=0, D6=local loopback, D7=all-ones request.
- R7: When event flags are set, (D5,D6,D7) is 110 for loss-of-signal only, 101 for driver-monitor only, and 111 for both. These codes take priority over R6.
- R8: Any change of `los_in` or `dpm_in` sets its flag and drives `irq_n` low within a few system clocks.
- R9: A flag clears only on a write with its clear bit set (D0 for loss-of-signal, D1 for driver-monitor) while its input is low. Otherwise the flag and `irq_n` stay asserted.
- R10: `rst_n` low, or a write with D5 = D6 = 1, clears the configuration and both flags to 0. A later read then returns 0x00.
- R11: `all_ones_en` is 0 while remote loopback is enabled, even when D7 was written as 1.
- R12: With `sdo_edge_sel` = 1, read bit k is valid at rising serial clock edge 9+k. With it at 0, bit k is valid at falling edge 8+k. Edges are counted from 1 within the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data in, sampled on rising sclk |
| sdo_edge_sel | input | 1 | 1: sdo valid on rising sclk; 0: valid on falling sclk |
| los_in | input | 1 | Loss-of-signal monitor level |
| dpm_in | input | 1 | Driver-monitor level |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable of the sdo pad |
| irq_n | output | 1 | Active-low latched interrupt (open-drain) |
| eq_code | output | 3 | Transmit equalizer code |
| rloop_en | output | 1 | Remote loopback enable |
| lloop_en | output | 1 | Local loopback enable |
| all_ones_en | output | 1 | Effective all-ones transmit enable |

## Verification
On every cycle, the assertions check several invariants. The configuration moves only on a commit strobe, and a commit lands the written fields. The reset command zeroes everything. `sdo_oe` drops once select is released and stays off during a commit. A monitor change pulls the interrupt, and the interrupt holds until a write arrives. The bench scenarios cover behaviour the assertions cannot see: the exact serial bit order, the status-code values and their priority, the rejection of unaddressed or aborted frames, and the edge on which each read bit is valid for both edge-select settings.

// File: rtl/shp_pkg.sv
// Shared constants and helpers for the serial host port.
// Assumes byte-wide command and data fields sent LSB first.
package shp_pkg;
    localparam int CMD_BITS  = 8;
    localparam int DATA_BITS = 8;
    localparam int RW_POS    = 0;   // command bit: 1 read, 0 write
    localparam int SEL_POS   = 5;   // command bit that addresses this port
    localparam int D_CLR_LOS = 0;
    localparam int D_CLR_DPM = 1;
    localparam int D_EQ_LO   = 2;
    localparam int D_RLOOP   = 5;
    localparam int D_LLOOP   = 6;
    localparam int D_ONES    = 7;

    typedef logic [DATA_BITS-1:0] byte_t;

    // Status field returned as {D7,D6,D5}: events outrank configuration.
    function automatic logic [2:0] status_field(input logic los_f, input logic dpm_f,
                                                input byte_t cfg);
        if (los_f || dpm_f)
            status_field = {dpm_f, los_f, 1'b1};
        else if (cfg[D_RLOOP])
            status_field = 3'b001;
        else
            status_field = {cfg[D_ONES], cfg[D_LLOOP], 1'b0};
    endfunction
endpackage

// File: rtl/shp_sync.sv
// Multi-stage synchronizer with edge detection for a vector of slow pins.
// Assumes each pin holds its level for more than STAGES+1 clocks.
module shp_sync #(
    parameter int               WIDTH  = 5,
    parameter int               STAGES = 2,
    parameter logic [WIDTH-1:0] INIT   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] last;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        // Shift the pin through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{INIT[g]}};
            else        chain <= {chain[STAGES-2:0], async_in[g]};
        end
        assign lvl[g] = chain[STAGES-1];
    end

    // Keep the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last <= INIT;
        else        last <= lvl;
    end

    assign rise = lvl & ~last;
    assign fall = ~lvl & last;
endmodule

// File: rtl/shp_shifter.sv
// Frame engine: collects command and data bits on rising sclk,
// issues a one-cycle commit strobe for addressed writes, and shifts
// the read byte out on the edge chosen by edge_sel.
// Assumes inputs are already synchronized single-cycle edge pulses.
module shp_shifter import shp_pkg::*; #(
    parameter int CMD_W = CMD_BITS,
    parameter int DAT_W = DATA_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic             cs_low,
    input  logic             cs_start,
    input  logic             sdi,
    input  logic             edge_sel,
    input  logic [DAT_W-1:0] rd_byte,
    output logic             wr_stb,
    output logic [DAT_W-1:0] wr_data,
    output logic             sdo,
    output logic             sdo_oe
);
    localparam int FRAME = CMD_W + DAT_W;
    localparam int CNT_W = $clog2(FRAME + 1);

    logic [CNT_W-1:0] cnt;
    logic             active;
    logic             rd_on;
    logic             hold_first;
    logic [CMD_W-1:0] cmd_sh;
    logic [CMD_W-1:0] cmd_next;
    logic [DAT_W-1:0] dat_sh;
    logic [DAT_W-1:0] dat_next;
    logic [DAT_W-1:0] osr;

    assign cmd_next = {sdi, cmd_sh[CMD_W-1:1]};
    assign dat_next = {sdi, dat_sh[DAT_W-1:1]};

    // Frame sequencing, bit capture, commit and read-out shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            active     <= 1'b0;
            rd_on      <= 1'b0;
            hold_first <= 1'b0;
            cmd_sh     <= '0;
            dat_sh     <= '0;
            osr        <= '0;
            wr_stb     <= 1'b0;
            wr_data    <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (cs_start) begin
                active <= 1'b1;
                cnt    <= '0;
                rd_on  <= 1'b0;
            end else if (!cs_low) begin
                active <= 1'b0;
                rd_on  <= 1'b0;
            end else if (active && sclk_rise && cnt < CNT_W'(FRAME)) begin
                cnt <= cnt + 1'b1;
                if (cnt < CNT_W'(CMD_W)) cmd_sh <= cmd_next;
                else                     dat_sh <= dat_next;
                if (rd_on && !edge_sel)
                    osr <= {1'b0, osr[DAT_W-1:1]};
                if (cnt == CNT_W'(CMD_W-1) && cmd_next[RW_POS] && cmd_next[SEL_POS]) begin
                    rd_on      <= 1'b1;
                    osr        <= rd_byte;
                    hold_first <= 1'b1;
                end
                if (cnt == CNT_W'(FRAME-1) && !cmd_sh[RW_POS] && cmd_sh[SEL_POS]) begin
                    wr_stb  <= 1'b1;
                    wr_data <= dat_next;
                end
            end else if (active && sclk_fall && rd_on && edge_sel) begin
                if (hold_first) hold_first <= 1'b0;
                else            osr <= {1'b0, osr[DAT_W-1:1]};
            end
        end
    end

    assign sdo_oe = rd_on;
    assign sdo    = rd_on & osr[0];
endmodule

// File: rtl/shp_cfgreg.sv
// Configuration byte and sticky monitor-change flags.
// Builds the read-back byte with the status field in its top bits.
// Assumes monitor levels are already synchronized.
module shp_cfgreg import shp_pkg::*; (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_stb,
    input  byte_t wr_data,
    input  logic  los_lvl,
    input  logic  dpm_lvl,
    output byte_t cfg,
    output logic  los_chg,
    output logic  dpm_chg,
    output byte_t rd_byte
);
    logic los_prev;
    logic dpm_prev;
    logic rst_cmd;

    assign rst_cmd = wr_stb && wr_data[D_RLOOP] && wr_data[D_LLOOP];

    // Configuration byte update on commit, or clear on reset command.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_cmd) cfg <= '0;
        else if (wr_stb)       cfg <= wr_data;
    end

    // Sticky change flags: a change wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            los_prev <= 1'b0;
            dpm_prev <= 1'b0;
            los_chg  <= 1'b0;
            dpm_chg  <= 1'b0;
        end else begin
            los_prev <= los_lvl;
            dpm_prev <= dpm_lvl;
            if (los_lvl != los_prev)
                los_chg <= 1'b1;
            else if (rst_cmd || (wr_stb && wr_data[D_CLR_LOS] && !los_lvl))
                los_chg <= 1'b0;
            if (dpm_lvl != dpm_prev)
                dpm_chg <= 1'b1;
            else if (rst_cmd || (wr_stb && wr_data[D_CLR_DPM] && !dpm_lvl))
                dpm_chg <= 1'b0;
        end
    end

    // Read-back: stored low bits, status field in D5..D7.
    always_comb begin
        rd_byte                    = cfg;
        {rd_byte[D_ONES], rd_byte[D_LLOOP], rd_byte[D_RLOOP]} =
            status_field(los_chg, dpm_chg, cfg);
    end
endmodule

// File: rtl/serial_host_port.sv
// Top of the serial host port: synchronizes pins, runs the frame
// engine and holds configuration plus monitor flags.
// Assumes sclk half period is several clk periods long.
module serial_host_port import shp_pkg::*; #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       sdi,
    input  logic       sdo_edge_sel,
    input  logic       los_in,
    input  logic       dpm_in,
    output logic       sdo,
    output logic       sdo_oe,
    output logic       irq_n,
    output logic [2:0] eq_code,
    output logic       rloop_en,
    output logic       lloop_en,
    output logic       all_ones_en
);
    localparam int NPIN = 5;

    logic [NPIN-1:0] pin_lvl;
    logic [NPIN-1:0] pin_rise;
    logic [NPIN-1:0] pin_fall;
    logic            cs_low;
    logic            wr_stb;
    byte_t           wr_data;
    byte_t           cfg;
    byte_t           rd_byte;
    logic            los_chg;
    logic            dpm_chg;
    logic            los_lvl;
    logic            dpm_lvl;

    shp_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES), .INIT(5'b00010)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({dpm_in, los_in, sdi, cs_n, sclk}),
        .lvl      (pin_lvl),
        .rise     (pin_rise),
        .fall     (pin_fall)
    );

    assign cs_low  = ~pin_lvl[1];
    assign los_lvl = pin_lvl[3];
    assign dpm_lvl = pin_lvl[4];

    shp_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (pin_rise[0]),
        .sclk_fall (pin_fall[0]),
        .cs_low    (cs_low),
        .cs_start  (pin_fall[1]),
        .sdi       (pin_lvl[2]),
        .edge_sel  (sdo_edge_sel),
        .rd_byte   (rd_byte),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

    shp_cfgreg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .los_lvl (los_lvl),
        .dpm_lvl (dpm_lvl),
        .cfg     (cfg),
        .los_chg (los_chg),
        .dpm_chg (dpm_chg),
        .rd_byte (rd_byte)
    );

    assign irq_n       = ~(los_chg | dpm_chg);
    assign eq_code     = cfg[D_EQ_LO+2:D_EQ_LO];
    assign rloop_en    = cfg[D_RLOOP];
    assign lloop_en    = cfg[D_LLOOP];
    assign all_ones_en = cfg[D_ONES] & ~cfg[D_RLOOP];
endmodule

// File: rtl/shp_checker.sv
// Cycle-level properties of the serial host port, bound to the top.
module shp_checker import shp_pkg::*; (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_low,
    input logic       wr_stb,
    input byte_t      wr_data,
    input logic       los_lvl,
    input logic       dpm_lvl,
    input logic       sdo_oe,
    input logic       irq_n,
    input logic [2:0] eq_code,
    input logic       rloop_en,
    input logic       lloop_en,
    input logic       all_ones_en
);
    // R3: configuration outputs move only after a commit strobe.
    assert_cfg_only_on_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable({eq_code, rloop_en, lloop_en}));

    // R1: a normal commit lands equalizer and loopback fields.
    assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !(wr_data[D_RLOOP] && wr_data[D_LLOOP])) |=>
        (eq_code == $past(wr_data[D_EQ_LO+2:D_EQ_LO]) && rloop_en == $past(wr_data[D_RLOOP])
         && lloop_en == $past(wr_data[D_LLOOP])));

    // R10: reset command zeroes the configuration and releases the interrupt.
    assert_reset_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_data[D_RLOOP] && wr_data[D_LLOOP] && $stable(los_lvl) && $stable(dpm_lvl))
        |=> (eq_code == 3'b000 && !rloop_en && !lloop_en && !all_ones_en && irq_n));

    // R4: output enable released once select is high.
    assert_oe_off_when_deselected_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_low |=> !sdo_oe);

    // R4: no output drive on a write commit.
    assert_oe_off_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !sdo_oe);

    // R8: any monitor change pulls the interrupt.
    assert_irq_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(los_lvl) || !$stable(dpm_lvl)) |=> !irq_n);

    // R9: an asserted interrupt holds until a write arrives.
    assert_irq_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !wr_stb) |=> !irq_n);
endmodule

bind serial_host_port shp_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_low      (cs_low),
    .wr_stb      (wr_stb),
    .wr_data     (wr_data),
    .los_lvl     (los_lvl),
    .dpm_lvl     (dpm_lvl),
    .sdo_oe      (sdo_oe),
    .irq_n       (irq_n),
    .eq_code     (eq_code),
    .rloop_en    (rloop_en),
    .lloop_en    (lloop_en),
    .all_ones_en (all_ones_en)
);

// File: tb/tb_serial_host_port.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_serial_host_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       sdi = 1'b0;
    logic       sdo_edge_sel = 1'b0;
    logic       los_in = 1'b0;
    logic       dpm_in = 1'b0;
    logic       sdo;
    logic       sdo_oe;
    logic       irq_n;
    logic [2:0] eq_code;
    logic       rloop_en;
    logic       lloop_en;
    logic       all_ones_en;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [7:0] CMD_WR   = 8'h20;
    localparam logic [7:0] CMD_RD   = 8'h21;
    localparam logic [7:0] CMD_NOSEL = 8'h00;
    localparam logic [7:0] CMD_RD_NOSEL = 8'h01;

    always #5 clk = ~clk;

    serial_host_port dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk         (sclk),
        .cs_n         (cs_n),
        .sdi          (sdi),
        .sdo_edge_sel (sdo_edge_sel),
        .los_in       (los_in),
        .dpm_in       (dpm_in),
        .sdo          (sdo),
        .sdo_oe       (sdo_oe),
        .irq_n        (irq_n),
        .eq_code      (eq_code),
        .rloop_en     (rloop_en),
        .lloop_en     (lloop_en),
        .all_ones_en  (all_ones_en)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One framed transfer of nbits; captures the read byte at the host's valid edge.
    task automatic xfer(input logic [7:0] cmd, input logic [7:0] din, input int nbits,
                        output logic [7:0] rd, output logic oe_seen);
        logic [15:0] frame;
        frame   = {din, cmd};
        rd      = 8'h00;
        oe_seen = 1'b0;
        cs_n    = 1'b0;
        tick(8);
        for (int i = 0; i < nbits; i++) begin
            sdi = frame[i];
            tick(4);
            oe_seen = oe_seen | sdo_oe;
            if (sdo_edge_sel && i >= 8) rd[i-8] = sdo;
            sclk = 1'b1;
            tick(7);
            oe_seen = oe_seen | sdo_oe;
            if (!sdo_edge_sel && i >= 7 && i <= 14) rd[i-7] = sdo;
            sclk = 1'b0;
            tick(4);
        end
        tick(8);
        cs_n = 1'b1;
        tick(10);
    endtask

    task automatic chk_cfg(input string req, input logic [2:0] eq, input logic rl,
                           input logic ll, input logic ones);
        chk({req, " eq_code"}, eq_code, eq);
        chk({req, " rloop_en"}, rloop_en, rl);
        chk({req, " lloop_en"}, lloop_en, ll);
        chk({req, " all_ones_en"}, all_ones_en, ones);
    endtask

    task automatic do_write(input logic [7:0] d);
        logic [7:0] r;
        logic oe;
        xfer(CMD_WR, d, 16, r, oe);
        chk("R4 no drive during write", oe, 1'b0);
        chk("R4 oe off after deselect", sdo_oe, 1'b0);
    endtask

    task automatic do_read(input string req, input logic sel, input logic [7:0] exp);
        logic [7:0] r;
        logic oe;
        sdo_edge_sel = sel;
        xfer(CMD_RD, 8'h00, 16, r, oe);
        chk({req, " read byte"}, r, exp);
        chk("R4 oe off after read", sdo_oe, 1'b0);
    endtask

    task automatic t_reset_state();
        chk("R10 reset irq_n", irq_n, 1'b1);
        chk("R4 reset sdo_oe", sdo_oe, 1'b0);
        chk_cfg("R10 reset", 3'b000, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_write_basic();
        do_write(8'h54);
        chk_cfg("R1 write", 3'b101, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_read_falling();
        do_read("R5 R6 R12 falling-edge", 1'b0, 8'h54);
    endtask

    task automatic t_read_rising();
        do_write(8'hD4);
        chk_cfg("R1 ones+local", 3'b101, 1'b0, 1'b1, 1'b1);
        do_read("R6 R12 rising-edge", 1'b1, 8'hD4);
    endtask

    task automatic t_remote_inhibit();
        do_write(8'hA0);
        chk_cfg("R11 remote inhibits ones", 3'b000, 1'b1, 1'b0, 1'b0);
        do_read("R6 remote code", 1'b0, 8'h20);
    endtask

    task automatic t_unaddressed();
        logic [7:0] r;
        logic oe;
        xfer(CMD_NOSEL, 8'h1C, 16, r, oe);
        chk_cfg("R2 unaddressed write", 3'b000, 1'b1, 1'b0, 1'b0);
        xfer(CMD_RD_NOSEL, 8'h00, 16, r, oe);
        chk("R2 unaddressed read no drive", oe, 1'b0);
    endtask

    task automatic t_abort();
        logic [7:0] r;
        logic oe;
        xfer(CMD_WR, 8'h1C, 12, r, oe);
        chk_cfg("R3 aborted write", 3'b000, 1'b1, 1'b0, 1'b0);
        xfer(CMD_WR, 8'h1C, 15, r, oe);
        chk_cfg("R3 abort at bit 15", 3'b000, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_events();
        los_in = 1'b1;
        tick(10);
        chk("R8 irq on los change", irq_n, 1'b0);
        do_read("R7 los code", 1'b1, 8'h60);
        do_write(8'hA1);
        chk("R9 clear refused while los high", irq_n, 1'b0);
        dpm_in = 1'b1;
        tick(10);
        do_read("R7 both code", 1'b0, 8'hE1);
        los_in = 1'b0;
        dpm_in = 1'b0;
        tick(10);
        chk("R9 flags kept after inputs drop", irq_n, 1'b0);
        do_write(8'hA3);
        chk("R9 cleared by write", irq_n, 1'b1);
        do_read("R6 after clear", 1'b0, 8'h23);
        dpm_in = 1'b1;
        tick(10);
        chk("R8 irq on dpm change", irq_n, 1'b0);
        do_read("R7 dpm code", 1'b1, 8'hA3);
    endtask

    task automatic t_reset_cmd();
        do_write(8'h60);
        chk_cfg("R10 reset command", 3'b000, 1'b0, 1'b0, 1'b0);
        chk("R10 reset command irq_n", irq_n, 1'b1);
        do_read("R10 read after reset", 1'b0, 8'h00);
    endtask

    initial begin
        tick(6);
        rst_n = 1'b1;
        tick(6);
        t_reset_state();
        t_write_basic();
        t_read_falling();
        t_read_rising();
        t_remote_inhibit();
        t_unaddressed();
        t_abort();
        t_events();
        t_reset_cmd();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule